// File: doc/BRIEF.md
# Multi-mode transmit capture serializer

This block takes one character at a time from a parallel transmit bus and sends it out one bit per clock. A character consists of a 10-bit bus, a 2-bit side command field and a select bit that picks data or command. The block captures these inputs on the same edge that loads its shift register. It does so only when its ready output is high and the enable input is at its active level. A polarity pin sets that active level.

Two mode pins choose one of four character formats:
- In the two encoded formats, the block splits the character into a high and a low group. It offers both groups, with a command flag, to an external symbol encoder through a combinational request/response port. It then shifts the two returned code groups out, most significant bit first.
- In the two pre-encoded formats, the raw bits go out least significant bit first. No encoder is involved.

When nothing is captured at a character boundary, the line carries a fixed idle pattern taken from a parameter.

Top module: `txcap_serializer`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released at a clock edge, `ser_out`, `ser_valid` and `ser_char` are 0 and `ready` is 1.
- R2: The enable is active when `tx_en` differs from `en_low`: high when `en_low`=0, low when `en_low`=1. A character is captured at a rising edge of `clk` only if `ready` is 1 and the enable is active at that edge. The first bit appears on `ser_out` right after that edge.
- R3: The mode is sampled at each character start from {`enc_on`,`narrow`}:
  - 11 is encoded-narrow, 10 bits long.
  - 10 is encoded-wide, 12 bits long.
  - 01 is raw-10, 10 bits long.
  - 00 is raw-12, 12 bits long.
  Changing these pins while a character is being sent does not alter that character.
- R4: In encoded-narrow mode with `tx_sel`=0, the two requests are as follows:
  - `enc_hi_grp` = {0,`tx_bus[7:4]`}.
  - `enc_lo_grp` = {0,`tx_bus[3:0]`}.
  - `enc_is_cmd` = 0 and `enc_wide` = 0.
  The line then carries `enc_hi_code[4:0]` from bit 4 down to bit 0, followed by `enc_lo_code[4:0]` in the same order.
- R5: In encoded-narrow mode with `tx_sel`=1, the 4-bit command is {`tx_bus[8]`,`tx_bus[9]`,`tx_xcmd[1]`,`tx_xcmd[0]`}. Bus bit 8 is command bit 3 and bus bit 9 is command bit 2. Both lanes carry this command, zero-extended, with `enc_is_cmd`=1. The serial order is the same as in R4.
- R6: In encoded-wide mode with `tx_sel`=0, `enc_hi_grp` = {bus 8,7,6,5,4} and `enc_lo_grp` = {bus 9,3,2,1,0}, with `enc_wide`=1. The line carries `enc_hi_code[5:0]` from bit 5 down to bit 0, then `enc_lo_code[5:0]` in the same order.
- R7: In encoded-wide mode with `tx_sel`=1, both lanes carry {000,`tx_xcmd[1:0]`} with `enc_is_cmd`=1. The serial order is the same as in R6.
- R8: In raw-10 mode the line carries `tx_bus[0]` through `tx_bus[9]`, in that order. `tx_sel` has no effect.
- R9: In raw-12 mode the line carries `tx_bus[0]` through `tx_bus[9]`, then `tx_xcmd[1]`, then `tx_xcmd[0]`. `tx_sel` has no effect.
- R10: `ready` is 1 exactly in the cycle in which the last bit of a character or idle slot is on `ser_out`, and 0 in every other cycle after that slot starts. A character captured at that edge follows with no gap.
- R11: If no character is captured at a slot boundary, the next slot has the length of the mode sampled at that boundary. It carries `IDLE_PAT` bit 0 upward with `ser_char`=0. `ser_char` is 1 during every bit of a captured character.
- R12: An active enable while `ready` is 0 is ignored. Neither the character in flight nor the following slot changes.
- R13: `ser_valid` becomes 1 at the first clock edge after reset and stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock and capture clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_bus | input | 10 | Parallel transmit bus |
| tx_xcmd | input | 2 | Side command bits 1:0 |
| tx_sel | input | 1 | 1 selects command, 0 selects data (encoded modes) |
| tx_en | input | 1 | Capture enable, polarity set by en_low |
| en_low | input | 1 | 1 makes tx_en active low |
| enc_on | input | 1 | Mode pin: 1 selects the encoded formats |
| narrow | input | 1 | Mode pin: 1 selects the shorter formats |
| enc_hi_grp | output | 5 | Encoder request, high group |
| enc_lo_grp | output | 5 | Encoder request, low group |
| enc_is_cmd | output | 1 | Encoder request is a command |
| enc_wide | output | 1 | Encoder request is a wide (5-bit) group |
| enc_hi_code | input | 6 | Encoder response for the high group |
| enc_lo_code | input | 6 | Encoder response for the low group |
| ready | output | 1 | Capture window: last bit of the slot on the line |
| ser_out | output | 1 | Serial line bit |
| ser_valid | output | 1 | Line bits are meaningful (set after reset) |
| ser_char | output | 1 | Current bit belongs to a captured character |

## Verification
The hardest situation to reach is a disturbance while a character is in flight: an active enable, new bus data and flipped mode pins, all while `ready` is low. Without one, the R3 and R12 claims are never tested. The bench does this inside the character-sending task. On a fixed subset of sweep values, it raises the enable, inverts the bus and flips both mode pins a few bits into the character, then restores them before the last bit. The exact bit stream is compared, and an idle slot of the restored mode's length must follow. A second hard case is a reset in the middle of a character. The bench produces it by launching a capture and asserting reset three bits later.

// File: rtl/txs_pkg.sv
package txs_pkg;
  // mode code = {enc_on, narrow}
  typedef enum logic [1:0] {
    MODE_RAW12 = 2'b00,
    MODE_RAW10 = 2'b01,
    MODE_ENCW  = 2'b10,
    MODE_ENCN  = 2'b11
  } txs_mode_e;
endpackage

// File: rtl/txs_lane_map.sv
module txs_lane_map
  import txs_pkg::*;
#(
  parameter int BUS_W  = 10,
  parameter int XCMD_W = 2,
  parameter int GRP_W  = 5,
  parameter int CHAR_W = BUS_W + XCMD_W
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [XCMD_W-1:0] xcmd,
  input  logic              sel,
  input  txs_mode_e         mode,
  output logic [GRP_W-1:0]  hi_grp,
  output logic [GRP_W-1:0]  lo_grp,
  output logic              is_cmd,
  output logic [CHAR_W-1:0] raw_seq
);
  localparam int NIB_W = GRP_W - 1;

  logic [NIB_W-1:0] narrow_cmd;
  assign narrow_cmd = {bus[8], bus[9], xcmd[1], xcmd[0]};

  always_comb begin
    hi_grp = '0;
    lo_grp = '0;
    is_cmd = 1'b0;
    case (mode)
      MODE_ENCN: begin
        if (sel) begin
          hi_grp[NIB_W-1:0] = narrow_cmd;
          lo_grp[NIB_W-1:0] = narrow_cmd;
          is_cmd            = 1'b1;
        end else begin
          hi_grp[NIB_W-1:0] = bus[7:4];
          lo_grp[NIB_W-1:0] = bus[3:0];
        end
      end
      MODE_ENCW: begin
        if (sel) begin
          hi_grp[XCMD_W-1:0] = xcmd;
          lo_grp[XCMD_W-1:0] = xcmd;
          is_cmd             = 1'b1;
        end else begin
          hi_grp = bus[8:4];
          lo_grp = {bus[9], bus[3:0]};
        end
      end
      default: ;
    endcase
  end

  // raw order: bus LSB first, then side command bits highest first
  for (genvar gi = 0; gi < BUS_W; gi++) begin : g_raw_bus
    assign raw_seq[gi] = bus[gi];
  end
  for (genvar gj = 0; gj < XCMD_W; gj++) begin : g_raw_cmd
    assign raw_seq[BUS_W+gj] = xcmd[XCMD_W-1-gj];
  end
endmodule

// File: rtl/txs_seq_build.sv
module txs_seq_build
  import txs_pkg::*;
#(
  parameter int BUS_W  = 10,
  parameter int GRP_W  = 5,
  parameter int CODE_W = 6,
  parameter int CHAR_W = 12,
  parameter int LEN_W  = 4
) (
  input  txs_mode_e         mode,
  input  logic [CODE_W-1:0] hi_code,
  input  logic [CODE_W-1:0] lo_code,
  input  logic [CHAR_W-1:0] raw_seq,
  output logic [CHAR_W-1:0] seq,
  output logic [LEN_W-1:0]  len
);
  always_comb begin
    seq = '0;
    len = LEN_W'(CHAR_W);
    case (mode)
      MODE_ENCN: begin
        for (int i = 0; i < GRP_W; i++) begin
          seq[i]       = hi_code[GRP_W-1-i];
          seq[GRP_W+i] = lo_code[GRP_W-1-i];
        end
        len = LEN_W'(2 * GRP_W);
      end
      MODE_ENCW: begin
        for (int i = 0; i < CODE_W; i++) begin
          seq[i]        = hi_code[CODE_W-1-i];
          seq[CODE_W+i] = lo_code[CODE_W-1-i];
        end
        len = LEN_W'(2 * CODE_W);
      end
      MODE_RAW10: begin
        seq[BUS_W-1:0] = raw_seq[BUS_W-1:0];
        len            = LEN_W'(BUS_W);
      end
      default: begin
        seq = raw_seq;
        len = LEN_W'(CHAR_W);
      end
    endcase
  end
endmodule

// File: rtl/txs_shifter.sv
module txs_shifter #(
  parameter int                CHAR_W   = 12,
  parameter int                LEN_W    = 4,
  parameter logic [CHAR_W-1:0] IDLE_PAT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_act,
  input  logic [CHAR_W-1:0] load_seq,
  input  logic [LEN_W-1:0]  len,
  output logic              ready,
  output logic              ser_out,
  output logic              ser_valid,
  output logic              ser_char
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

  logic [CHAR_W-1:0] sh;
  logic [LEN_W-1:0]  rem;
  logic              ready_q, valid_q, char_q, take;

  assign take = ready_q & en_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      rem     <= ONE;
      ready_q <= 1'b1;
      valid_q <= 1'b0;
      char_q  <= 1'b0;
    end else if (rem == ONE) begin
      sh      <= take ? load_seq : IDLE_PAT;
      rem     <= len;
      ready_q <= 1'b0;
      valid_q <= 1'b1;
      char_q  <= take;
    end else begin
      sh      <= sh >> 1;
      rem     <= rem - ONE;
      ready_q <= (rem == TWO);
    end
  end

  assign ready     = ready_q;
  assign ser_out   = sh[0];
  assign ser_valid = valid_q;
  assign ser_char  = char_q;

  a_r10_ready_last_bit: assert property (@(posedge clk) disable iff (rst)
    ready_q == (rem == ONE));
  a_r3_countdown: assert property (@(posedge clk) disable iff (rst)
    (rem != ONE) |=> (rem == $past(rem) - ONE));
  a_r3_reload_length: assert property (@(posedge clk) disable iff (rst)
    (rem == ONE) |=> (rem == $past(len)));
  a_r13_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> valid_q);
  a_r11_kind_steady: assert property (@(posedge clk) disable iff (rst)
    (rem != ONE) |=> $stable(char_q));
endmodule

// File: rtl/txcap_serializer.sv
module txcap_serializer
  import txs_pkg::*;
#(
  parameter int                            BUS_W    = 10,
  parameter int                            XCMD_W   = 2,
  parameter int                            GRP_W    = 5,
  parameter int                            CODE_W   = 6,
  parameter logic [BUS_W+XCMD_W-1:0]       IDLE_PAT = 12'h3E9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  tx_bus,
  input  logic [XCMD_W-1:0] tx_xcmd,
  input  logic              tx_sel,
  input  logic              tx_en,
  input  logic              en_low,
  input  logic              enc_on,
  input  logic              narrow,
  output logic [GRP_W-1:0]  enc_hi_grp,
  output logic [GRP_W-1:0]  enc_lo_grp,
  output logic              enc_is_cmd,
  output logic              enc_wide,
  input  logic [CODE_W-1:0] enc_hi_code,
  input  logic [CODE_W-1:0] enc_lo_code,
  output logic              ready,
  output logic              ser_out,
  output logic              ser_valid,
  output logic              ser_char
);
  localparam int CHAR_W = BUS_W + XCMD_W;
  localparam int LEN_W  = $clog2(CHAR_W + 1);

  txs_mode_e         mode;
  logic [CHAR_W-1:0] raw_seq, seq;
  logic [LEN_W-1:0]  len;
  logic              en_act;

  assign mode     = txs_mode_e'({enc_on, narrow});
  assign en_act   = tx_en ^ en_low;
  assign enc_wide = ~narrow;

  txs_lane_map #(
    .BUS_W(BUS_W), .XCMD_W(XCMD_W), .GRP_W(GRP_W), .CHAR_W(CHAR_W)
  ) u_map (
    .bus(tx_bus), .xcmd(tx_xcmd), .sel(tx_sel), .mode(mode),
    .hi_grp(enc_hi_grp), .lo_grp(enc_lo_grp), .is_cmd(enc_is_cmd),
    .raw_seq(raw_seq)
  );

  txs_seq_build #(
    .BUS_W(BUS_W), .GRP_W(GRP_W), .CODE_W(CODE_W),
    .CHAR_W(CHAR_W), .LEN_W(LEN_W)
  ) u_build (
    .mode(mode), .hi_code(enc_hi_code), .lo_code(enc_lo_code),
    .raw_seq(raw_seq), .seq(seq), .len(len)
  );

  txs_shifter #(
    .CHAR_W(CHAR_W), .LEN_W(LEN_W), .IDLE_PAT(IDLE_PAT)
  ) u_shift (
    .clk(clk), .rst(rst), .en_act(en_act), .load_seq(seq), .len(len),
    .ready(ready), .ser_out(ser_out), .ser_valid(ser_valid),
    .ser_char(ser_char)
  );

  a_r12_start_needs_ready: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_char) |-> $past(ready));
  a_r2_capture_marks_char: assert property (@(posedge clk) disable iff (rst)
    (ready && en_act) |=> ser_char);
endmodule

// File: tb/txcap_serializer_bench.sv
`timescale 1ns/1ps
module txcap_serializer_bench;
  localparam logic [11:0] IDLE = 12'h3E9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] tx_bus = '0;
  logic [1:0] tx_xcmd = '0;
  logic       tx_sel = 1'b0, tx_en = 1'b0, en_low = 1'b0;
  logic       enc_on = 1'b0, narrow = 1'b1;
  logic [4:0] enc_hi_grp, enc_lo_grp;
  logic       enc_is_cmd, enc_wide;
  logic [5:0] enc_hi_code, enc_lo_code;
  logic       ready, ser_out, ser_valid, ser_char;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  function automatic logic [5:0] enc_model(logic [4:0] g, logic c, logic w);
    if (w) return {g[0], ~g[4], g[3:1], ^g} ^ (c ? 6'b101101 : 6'b0);
    return {1'b0, {g[1:0], ~^g[3:0], g[3:2]} ^ (c ? 5'b10110 : 5'b0)};
  endfunction

  assign enc_hi_code = enc_model(enc_hi_grp, enc_is_cmd, enc_wide);
  assign enc_lo_code = enc_model(enc_lo_grp, enc_is_cmd, enc_wide);

  txcap_serializer #(.IDLE_PAT(IDLE)) u_txcap_serializer (
    .clk(clk), .rst(rst), .tx_bus(tx_bus), .tx_xcmd(tx_xcmd),
    .tx_sel(tx_sel), .tx_en(tx_en), .en_low(en_low), .enc_on(enc_on),
    .narrow(narrow), .enc_hi_grp(enc_hi_grp), .enc_lo_grp(enc_lo_grp),
    .enc_is_cmd(enc_is_cmd), .enc_wide(enc_wide),
    .enc_hi_code(enc_hi_code), .enc_lo_code(enc_lo_code),
    .ready(ready), .ser_out(ser_out), .ser_valid(ser_valid),
    .ser_char(ser_char)
  );

  task automatic check(bit ok, string tag, string what,
                       logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // expected line sequence (bit i sent i-th) built from the requirements
  function automatic void exp_char(input logic [1:0] m, input logic [9:0] b,
                                   input logic [1:0] c, input logic s,
                                   output logic [11:0] seq, output int len);
    logic [4:0] gh, gl;
    logic [5:0] ch, cl;
    seq = '0;
    case (m)
      2'b11: begin // R4 / R5
        gh = s ? {1'b0, b[8], b[9], c} : {1'b0, b[7:4]};
        gl = s ? {1'b0, b[8], b[9], c} : {1'b0, b[3:0]};
        ch = enc_model(gh, s, 1'b0);
        cl = enc_model(gl, s, 1'b0);
        for (int i = 0; i < 5; i++) begin
          seq[i] = ch[4-i]; seq[5+i] = cl[4-i];
        end
        len = 10;
      end
      2'b10: begin // R6 / R7
        gh = s ? {3'b0, c} : b[8:4];
        gl = s ? {3'b0, c} : {b[9], b[3:0]};
        ch = enc_model(gh, s, 1'b1);
        cl = enc_model(gl, s, 1'b1);
        for (int i = 0; i < 6; i++) begin
          seq[i] = ch[5-i]; seq[6+i] = cl[5-i];
        end
        len = 12;
      end
      2'b01: begin seq[9:0] = b; len = 10; end  // R8
      default: begin seq = {c[0], c[1], b}; len = 12; end  // R9
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] m, logic s);
    case (m)
      2'b11: return s ? "R5" : "R4";
      2'b10: return s ? "R7" : "R6";
      2'b01: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic send(logic [1:0] m, logic [9:0] b, logic [1:0] c,
                      logic s, logic pol, bit poke);
    logic [11:0] seq, got, mask;
    int len;
    bit rdy_ok = 1, chr_ok = 1;
    while (!ready) @(negedge clk);
    enc_on = m[1]; narrow = m[0]; tx_bus = b; tx_xcmd = c; tx_sel = s;
    en_low = pol; tx_en = ~pol;                       // R2 active level
    @(posedge clk); #1;
    tx_en = pol;
    exp_char(m, b, c, s, seq, len);
    got = '0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      got[i] = ser_out;
      if (ready !== (i == len - 1)) rdy_ok = 0;
      if (ser_char !== 1'b1) chr_ok = 0;
      if (poke && i == 2) begin   // R12 / R3 disturbance
        tx_en = ~pol; tx_bus = ~b; enc_on = ~m[1]; narrow = ~m[0];
      end
      if (poke && i == 4) begin
        tx_en = pol; tx_bus = b; enc_on = m[1]; narrow = m[0];
      end
    end
    mask = (len == 12) ? 12'hFFF : 12'h3FF;
    check(((got ^ seq) & mask) == 0, tag_of(m, s), "line bits", 32'(got), 32'(seq));
    check(rdy_ok, "R10", "ready only on last bit", 32'(rdy_ok), 1);
    check(chr_ok, "R11", "ser_char during character", 32'(chr_ok), 1);
  endtask

  task automatic idle_slot(int len, logic pol, string tag);
    logic [11:0] got, mask;
    bit kind_ok = 1, vld_ok = 1;
    while (!ready) @(negedge clk);
    en_low = pol; tx_en = pol;  // inactive level
    @(posedge clk);
    got = '0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      got[i] = ser_out;
      if (ser_char !== 1'b0) kind_ok = 0;
      if (ser_valid !== 1'b1) vld_ok = 0;
    end
    mask = (len == 12) ? 12'hFFF : 12'h3FF;
    check(((got ^ IDLE) & mask) == 0 && ready === 1'b1, tag, "idle slot bits/length",
          32'(got), 32'(IDLE & mask));
    check(kind_ok, "R11", "ser_char low in idle", 32'(kind_ok), 1);
    check(vld_ok, "R13", "ser_valid held", 32'(vld_ok), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({ser_out, ser_valid, ser_char, ready} == 4'b0001, "R1", "reset outputs",
          32'({ser_out, ser_valid, ser_char, ready}), 32'h1);
    rst = 1'b0;
    // first slot after reset: raw-10 idle, polarity active-low path
    enc_on = 1'b0; narrow = 1'b1;
    idle_slot(10, 1'b1, "R11");

    // exhaustive bus sweep in all four modes, varied command/select/polarity
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < 1024; v++) begin
        logic [9:0] b = 10'(v);
        send(2'(m), b, b[3:2] ^ b[9:8], b[4] ^ b[7], b[6], b[3:0] == 4'hA);
      end
    end

    // R12: disturbed character, then the following slot must be idle
    send(2'b01, 10'h2C5, 2'b10, 1'b0, 1'b0, 1'b1);
    enc_on = 1'b0; narrow = 1'b1;
    idle_slot(10, 1'b0, "R12");
    // R3: length of idle slots follows the sampled mode
    enc_on = 1'b1; narrow = 1'b0;
    idle_slot(12, 1'b0, "R3");
    enc_on = 1'b0; narrow = 1'b0;
    idle_slot(12, 1'b1, "R3");
    // R2: inactive level with active-low polarity captures nothing
    enc_on = 1'b1; narrow = 1'b1;
    idle_slot(10, 1'b1, "R2");

    // R1: reset in the middle of a character
    while (!ready) @(negedge clk);
    enc_on = 1'b0; narrow = 1'b0; tx_bus = 10'h155; en_low = 1'b0; tx_en = 1'b1;
    @(posedge clk); #1; tx_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check({ser_out, ser_valid, ser_char, ready} == 4'b0001, "R1", "mid-character reset",
          32'({ser_out, ser_valid, ser_char, ready}), 32'h1);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check(ser_valid === 1'b1 && ser_char === 1'b0, "R13", "valid after reset release",
          32'({ser_valid, ser_char}), 32'h2);
    send(2'b10, 10'h3A7, 2'b01, 1'b1, 1'b1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule